// File: doc/BRIEF.md
# Multi-Lane Serial Link Reset Sequencer

This block brings a four-lane serial link front end out of power-down and reset under hardware timing, so that software only issues a start request and waits for a completion pulse. In the stepped mode it first forces every power-down, PLL reset, lane reset and coding-layer reset on together. It then releases the first lane pair and afterwards the second, each in the order power-down, PLL, lane reset. Next it writes default drive-strength and equalization values to the lanes, and finally clears the whole control word. One fixed wait interval separates every step.

In the alternative poll mode the block raises a single self-clearing link reset request and watches a status input once per interval. When the status reports the reset finished it withdraws the request, writes the drive defaults and signals completion. If the status never clears within the poll budget it withdraws the request and signals a timeout. The drive/equalization write is suppressed in both modes when no PHY is fitted. The interval length, the poll budget, the number of lane pairs and the drive field widths and defaults are all parameters.

Top module: `lane_reset_sequencer`

## Requirements
- R1: After reset the control word is all zero and done, timeout and the config strobe are low.
- R2: A start accepted in stepped mode (poll select low) sets control bits [11:0] to ones and bit 12 to zero in the cycle after the start edge, and holds that value for exactly WAIT_CYC cycles. Control word layout: bits [3:0] lane power-down A..D, [4] PLL reset pair AB, [5] PLL reset pair CD, [9:6] lane reset A..D, [10] transmit coding reset, [11] receive coding reset, [12] self-clearing link reset request.
- R3: Pair A/B is released first: one interval after the all-on step bits 0 and 1 clear, one interval later bit 4 clears, one interval later bits 6 and 7 clear. No released bit returns high during the sequence.
- R4: Pair C/D follows the same three steps in the next three intervals: bits 2 and 3, then bit 5, then bits 8 and 9.
- R5: One interval after the C/D lane resets clear, the config strobe pulses for one cycle if the PHY-present input is high and not at all otherwise. The config word holds, for each lane i, a 6-bit field at bits [6i+5:6i] with drive strength in the upper 4 bits (default 5) and equalization in the lower 2 bits (default 1), giving 0x555555.
- R6: One interval after the config step the control word becomes zero; one interval later done pulses for one cycle, so done arrives 9 intervals after the start edge.
- R7: A start request, or a change of the poll select, while a sequence is running has no effect on the control word, strobe, done or timeout.
- R8: A start accepted in poll mode sets only bit 12 of the control word; the status input is sampled at the end of each interval, and at the first sample showing it low the control word becomes zero, done pulses and the config strobe pulses if a PHY is present, all in the same cycle.
- R9: If the status input is still high at the POLL_MAX-th sample, the control word becomes zero and timeout pulses for one cycle, with no done and no config strobe.
- R10: Done and timeout are single-cycle pulses, are never high together, and each leaves the block idle so the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| poll_mode_i | input | 1 | 1 selects the self-clearing poll mode, 0 the stepped mode |
| phy_present_i | input | 1 | High when a PHY is fitted; enables the drive/equalization write |
| selfclr_busy_i | input | 1 | Status of the self-clearing link reset, high while it is still in progress |
| ctl_word_o | output | 13 | Power-down and reset control word |
| cfg_word_o | output | 24 | Default drive/equalization word, one 6-bit field per lane |
| cfg_we_o | output | 1 | One-cycle strobe writing cfg_word_o to the lanes |
| done_o | output | 1 | One-cycle pulse on successful completion |
| timeout_o | output | 1 | One-cycle pulse when the poll budget runs out |

## Verification
On every cycle the assertions check that a stepped sequence never re-asserts a bit it has released, that the control word only moves on an interval boundary whatever happens on the start and mode inputs, that the poll mode drives only the request bit, that the poll count stays in range, and that done and timeout are exclusive single-cycle pulses leaving a cleared word. The exact release order, the cycle on which each step lands, the presence or absence of the config strobe for a given PHY setting, and the poll outcome for a given status waveform can only be shown by the bench's scenarios, which predict every output change with its cycle number and compare them in order.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_STEP = 2'd1,
      SEQ_POLL = 2'd2
   } seq_state_e;

   // Control word layout, derived from the number of lane pairs.
   function automatic int pd_base(input int np);
      return 0;
   endfunction

   function automatic int pll_base(input int np);
      return 2 * np;
   endfunction

   function automatic int rst_base(input int np);
      return 3 * np;
   endfunction

   function automatic int txc_bit(input int np);
      return 5 * np;
   endfunction

   function automatic int rxc_bit(input int np);
      return 5 * np + 1;
   endfunction

   function automatic int sc_bit(input int np);
      return 5 * np + 2;
   endfunction

   function automatic int ctl_width(input int np);
      return 5 * np + 3;
   endfunction

endpackage

// File: rtl/lrs_interval_timer.sv
module lrs_interval_timer #(
   parameter int WAIT_CYC = 1250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic tick
);
   localparam int CW = (WAIT_CYC > 2) ? $clog2(WAIT_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

   logic [CW-1:0] cnt_q;

   initial assert (WAIT_CYC >= 2) else $error("WAIT_CYC must be at least 2");

   assign tick = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= tick ? '0 : cnt_q + CW'(1);
      end
   end

   // Interval boundaries are at least WAIT_CYC apart, never back to back.
   assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/lrs_poll_counter.sv
module lrs_poll_counter #(
   parameter int POLL_MAX = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic poll,
   output logic last
);
   localparam int PW = (POLL_MAX > 2) ? $clog2(POLL_MAX) : 1;
   localparam logic [PW-1:0] LAST = PW'(POLL_MAX - 1);

   logic [PW-1:0] cnt_q;

   initial assert (POLL_MAX >= 2) else $error("POLL_MAX must be at least 2");

   assign last = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (poll && !last) begin
         cnt_q <= cnt_q + PW'(1);
      end
   end

   assert_poll_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/lrs_step_decode.sv
module lrs_step_decode
   import lrs_pkg::*;
#(
   parameter int NUM_PAIRS = 2,
   parameter int PHW       = 4,
   localparam int CTLW     = ctl_width(NUM_PAIRS)
) (
   input  logic [PHW-1:0]  phase,
   output logic [CTLW-1:0] word
);
   localparam int PD   = pd_base(NUM_PAIRS);
   localparam int PLL  = pll_base(NUM_PAIRS);
   localparam int RST  = rst_base(NUM_PAIRS);
   localparam int TXC  = txc_bit(NUM_PAIRS);
   localparam int RXC  = rxc_bit(NUM_PAIRS);
   localparam int SC   = sc_bit(NUM_PAIRS);
   localparam int CLR_PHASE = 3 * NUM_PAIRS + 2;
   localparam logic [PHW-1:0] CLR_V = PHW'(CLR_PHASE);

   initial assert ((1 << PHW) > CLR_PHASE) else $error("phase width too small");

   // Pair k releases power-down, PLL, lane reset at phases 3k+1, 3k+2, 3k+3.
   for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
      assign word[PD + 2*k +: 2]  = {2{phase < PHW'(3*k + 1)}};
      assign word[PLL + k]        = phase < PHW'(3*k + 2);
      assign word[RST + 2*k +: 2] = {2{phase < PHW'(3*k + 3)}};
   end

   assign word[TXC] = phase < CLR_V;
   assign word[RXC] = phase < CLR_V;
   assign word[SC]  = 1'b0;

endmodule

// File: rtl/lane_reset_sequencer.sv
module lane_reset_sequencer
   import lrs_pkg::*;
#(
   parameter int NUM_PAIRS = 2,
   parameter int WAIT_CYC  = 1250,
   parameter int POLL_MAX  = 1000,
   parameter int DRV_W     = 4,
   parameter int EQ_W      = 2,
   parameter int DRV_DEF   = 5,
   parameter int EQ_DEF    = 1,
   localparam int LANES    = 2 * NUM_PAIRS,
   localparam int LW       = DRV_W + EQ_W,
   localparam int CTLW     = ctl_width(NUM_PAIRS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic                  poll_mode_i,
   input  logic                  phy_present_i,
   input  logic                  selfclr_busy_i,
   output logic [CTLW-1:0]       ctl_word_o,
   output logic [LANES*LW-1:0]   cfg_word_o,
   output logic                  cfg_we_o,
   output logic                  done_o,
   output logic                  timeout_o
);
   localparam int CFG_PHASE = 3 * NUM_PAIRS + 1;
   localparam int CLR_PHASE = CFG_PHASE + 1;
   localparam int PHW       = $clog2(CLR_PHASE + 1);
   localparam logic [PHW-1:0] CFG_V = PHW'(CFG_PHASE);
   localparam logic [PHW-1:0] CLR_V = PHW'(CLR_PHASE);
   localparam logic [CTLW-1:0] SC_ONLY = CTLW'(1) << sc_bit(NUM_PAIRS);

   initial assert (NUM_PAIRS >= 1) else $error("NUM_PAIRS must be at least 1");
   initial assert (DRV_W >= 1 && EQ_W >= 1) else $error("field widths must be positive");
   initial assert (DRV_DEF < (1 << DRV_W) && EQ_DEF < (1 << EQ_W))
      else $error("default drive/equalization value does not fit its field");

   seq_state_e      state_q;
   logic [PHW-1:0]  phase_q;
   logic [PHW-1:0]  dec_phase;
   logic [CTLW-1:0] ctl_q;
   logic [CTLW-1:0] step_word;
   logic            cfg_we_q, done_q, tmo_q;
   logic            tick, poll_last, accept;

   // Per-lane drive/equalization defaults.
   for (genvar i = 0; i < LANES; i++) begin : g_lane_cfg
      assign cfg_word_o[i*LW +: LW] = {DRV_W'(DRV_DEF), EQ_W'(EQ_DEF)};
   end

   assign accept    = (state_q == SEQ_IDLE) && start_i;
   assign dec_phase = (state_q == SEQ_IDLE) ? '0 : phase_q + PHW'(1);

   lrs_interval_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .run     (state_q != SEQ_IDLE),
      .tick    (tick)
   );

   lrs_poll_counter #(.POLL_MAX(POLL_MAX)) u_polls (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .poll    ((state_q == SEQ_POLL) && tick),
      .last    (poll_last)
   );

   lrs_step_decode #(.NUM_PAIRS(NUM_PAIRS), .PHW(PHW)) u_decode (
      .phase (dec_phase),
      .word  (step_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SEQ_IDLE;
         phase_q  <= '0;
         ctl_q    <= '0;
         cfg_we_q <= 1'b0;
         done_q   <= 1'b0;
         tmo_q    <= 1'b0;
      end else begin
         cfg_we_q <= 1'b0;
         done_q   <= 1'b0;
         tmo_q    <= 1'b0;
         case (state_q)
            SEQ_IDLE: begin
               if (start_i) begin
                  if (poll_mode_i) begin
                     state_q <= SEQ_POLL;
                     ctl_q   <= SC_ONLY;
                  end else begin
                     state_q <= SEQ_STEP;
                     phase_q <= '0;
                     ctl_q   <= step_word;
                  end
               end
            end
            SEQ_STEP: begin
               if (tick) begin
                  if (phase_q == CLR_V) begin
                     state_q <= SEQ_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     phase_q <= dec_phase;
                     ctl_q   <= step_word;
                     if (dec_phase == CFG_V) cfg_we_q <= phy_present_i;
                  end
               end
            end
            SEQ_POLL: begin
               if (tick) begin
                  if (!selfclr_busy_i) begin
                     state_q  <= SEQ_IDLE;
                     ctl_q    <= '0;
                     done_q   <= 1'b1;
                     cfg_we_q <= phy_present_i;
                  end else if (poll_last) begin
                     state_q <= SEQ_IDLE;
                     ctl_q   <= '0;
                     tmo_q   <= 1'b1;
                  end
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign ctl_word_o = ctl_q;
   assign cfg_we_o   = cfg_we_q;
   assign done_o     = done_q;
   assign timeout_o  = tmo_q;

   // A stepped sequence only ever releases bits.
   assert_no_reassert_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_STEP && $past(state_q) == SEQ_STEP) |-> ((ctl_q & ~$past(ctl_q)) == '0));

   // Between interval boundaries nothing moves, start pulses included.
   assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != SEQ_IDLE && !tick) |=> ($stable(ctl_q) && !done_q && !tmo_q && !cfg_we_q));

   assert_poll_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_POLL) |-> (ctl_q == SC_ONLY));

   assert_tmo_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (ctl_word_o == '0 && !cfg_we_o && state_q == SEQ_IDLE));

   assert_cfg_phy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we_o |-> $past(phy_present_i));

   assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ctl_word_o == '0 && state_q == SEQ_IDLE));

   assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && timeout_o));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_tmo_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> !timeout_o);

endmodule

// File: tb/tb_lane_reset_sequencer.sv
`timescale 1ns/1ps
module tb_lane_reset_sequencer;
   localparam int W  = 8;
   localparam int PM = 5;
   localparam int WATCHDOG = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        poll_mode = 1'b0;
   logic        phy = 1'b1;
   logic        busy = 1'b1;
   logic [12:0] ctl;
   logic [23:0] cfg_word;
   logic        cfg_we, done, tmo;

   always #4 clk = ~clk;

   lane_reset_sequencer #(.WAIT_CYC(W), .POLL_MAX(PM)) dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start),
      .poll_mode_i    (poll_mode),
      .phy_present_i  (phy),
      .selfclr_busy_i (busy),
      .ctl_word_o     (ctl),
      .cfg_word_o     (cfg_word),
      .cfg_we_o       (cfg_we),
      .done_o         (done),
      .timeout_o      (tmo)
   );

   typedef struct {
      int          at;
      logic [12:0] ctl;
      logic        cfg;
      logic        dn;
      logic        to;
      int          req;
   } exp_t;

   exp_t        q[$];
   int          cyc = 0;
   int          checks = 0;
   int          errors = 0;
   int          cur_req = 1;
   logic [12:0] last_ctl = '0;

   always @(posedge clk) cyc <= cyc + 1;

   // Expected control word after n release steps (layout in R2).
   function automatic logic [12:0] step_word(input int n);
      case (n)
         0: return 13'h0FFF;
         1: return 13'h0FFC;   // R3 power-down A,B
         2: return 13'h0FEC;   // R3 PLL AB
         3: return 13'h0F2C;   // R3 lane reset A,B
         4: return 13'h0F20;   // R4 power-down C,D
         5: return 13'h0F00;   // R4 PLL CD
         6: return 13'h0C00;   // R4 lane reset C,D
         default: return 13'h0000;
      endcase
   endfunction

   task automatic push(input int at, input logic [12:0] c, input logic cf,
                       input logic dn, input logic to, input int req);
      exp_t e;
      e.at = at; e.ctl = c; e.cfg = cf; e.dn = dn; e.to = to; e.req = req;
      q.push_back(e);
   endtask

   // Monitor: every output change or pulse is matched against the queue.
   always @(negedge clk) begin
      if (rst_n) begin
         if (ctl !== last_ctl || done || tmo || cfg_we) begin
            checks++;
            if (q.size() == 0) begin
               errors++;
               $display("FAIL R%0d unexpected event: actual cyc=%0d ctl=%h cfg=%b done=%b tmo=%b expected no event",
                        cur_req, cyc, ctl, cfg_we, done, tmo);
            end else begin
               exp_t e;
               e = q.pop_front();
               if (cyc != e.at || ctl !== e.ctl || cfg_we !== e.cfg || done !== e.dn || tmo !== e.to) begin
                  errors++;
                  $display("FAIL R%0d actual cyc=%0d ctl=%h cfg=%b done=%b tmo=%b expected cyc=%0d ctl=%h cfg=%b done=%b tmo=%b",
                           e.req, cyc, ctl, cfg_we, done, tmo, e.at, e.ctl, e.cfg, e.dn, e.to);
               end
            end
         end
         last_ctl = ctl;
      end
   end

   always @(posedge clk) begin
      if (cyc >= WATCHDOG) begin
         errors++;
         $display("FAIL R10 watchdog: actual cyc=%0d expected finish before %0d", cyc, WATCHDOG);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wait_cyc(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   // Returns the cycle number at which the start will be seen.
   task automatic begin_at(output int e0);
      @(negedge clk);
      e0 = cyc + 1;
   endtask

   task automatic fire(input logic pm);
      poll_mode = pm;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic drain(input int endcyc, input int req);
      wait_cyc(endcyc + 2 * W);
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL R%0d missing events: actual pending=%0d expected 0", req, q.size());
         q.delete();
      end
   endtask

   task automatic run_stepped(input logic has_phy, input logic stray);
      int e0;
      phy = has_phy;
      begin_at(e0);
      push(e0, step_word(0), 1'b0, 1'b0, 1'b0, 2);          // R2
      for (int n = 1; n <= 6; n++)
         push(e0 + n * W, step_word(n), 1'b0, 1'b0, 1'b0, (n <= 3) ? 3 : 4);
      if (has_phy) push(e0 + 7 * W, step_word(6), 1'b1, 1'b0, 1'b0, 5);  // R5
      push(e0 + 8 * W, 13'h0000, 1'b0, 1'b0, 1'b0, 6);      // R6
      push(e0 + 9 * W, 13'h0000, 1'b0, 1'b1, 1'b0, 6);      // R6 done
      fire(1'b0);
      if (stray) begin
         // R7: starts and mode change in the middle of the run
         wait_cyc(e0 + 3);
         fire(1'b1);
         wait_cyc(e0 + 4 * W + 1);
         fire(1'b0);
         wait_cyc(e0 + 7 * W);
         fire(1'b1);
         poll_mode = 1'b0;
      end
      drain(e0 + 9 * W, 6);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (ctl !== 13'h0 || done !== 1'b0 || tmo !== 1'b0 || cfg_we !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: actual ctl=%h done=%b tmo=%b cfg=%b expected all zero", ctl, done, tmo, cfg_we);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (ctl !== 13'h0 || done !== 1'b0 || tmo !== 1'b0 || cfg_we !== 1'b0) begin
         errors++;
         $display("FAIL R1 after release: actual ctl=%h expected 0", ctl);
      end
      // R5: default drive/equalization word
      checks++;
      if (cfg_word !== 24'h555555) begin
         errors++;
         $display("FAIL R5 cfg word: actual %h expected 555555", cfg_word);
      end

      // Stepped, PHY present, stray starts (R2 R3 R4 R5 R6 R7)
      cur_req = 7;
      run_stepped(1'b1, 1'b1);
      // Stepped, no PHY: no config strobe (R5)
      cur_req = 5;
      run_stepped(1'b0, 1'b0);

      begin : poll_late
         int e0;
         // R8: status clears before the third sample, PHY present
         cur_req = 8;
         phy = 1'b1;
         busy = 1'b1;
         begin_at(e0);
         push(e0, 13'h1000, 1'b0, 1'b0, 1'b0, 8);
         push(e0 + 3 * W, 13'h0000, 1'b1, 1'b1, 1'b0, 8);
         fire(1'b1);
         wait_cyc(e0 + 2 * W + 1);
         busy = 1'b0;
         drain(e0 + 3 * W, 8);
      end

      begin : poll_first
         int e0;
         // R8: status already clear at the first sample, no PHY
         phy = 1'b0;
         busy = 1'b0;
         begin_at(e0);
         push(e0, 13'h1000, 1'b0, 1'b0, 1'b0, 8);
         push(e0 + W, 13'h0000, 1'b0, 1'b1, 1'b0, 8);
         fire(1'b1);
         drain(e0 + W, 8);
      end

      begin : poll_stuck
         int e0;
         // R9: status never clears; stray start mid-poll (R7)
         cur_req = 9;
         phy = 1'b1;
         busy = 1'b1;
         begin_at(e0);
         push(e0, 13'h1000, 1'b0, 1'b0, 1'b0, 8);
         push(e0 + PM * W, 13'h0000, 1'b0, 1'b0, 1'b1, 9);
         fire(1'b1);
         wait_cyc(e0 + W + 2);
         fire(1'b0);
         drain(e0 + PM * W, 9);
      end

      // R10: block is idle again after a timeout; a stepped run follows
      cur_req = 10;
      busy = 1'b0;
      run_stepped(1'b1, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule